// File: doc/BRIEF.md
# I2C Target Transmit Preload Controller

This block decides what an I2C target puts on the wire when a controller starts a read, in the case where firmware wants the reply bytes staged ahead of time. Firmware turns on preload mode and clears any lockout left by an earlier error. It then pushes the reply bytes into the external transmit FIFO and raises a ready bit. When the bus engine reports the next controller read, the block opens a read session and streams the staged bytes from the FIFO to the byte serializer. It clears the ready bit on its own, so that a later read cannot resend stale data.

If a controller read arrives while preload mode is on but ready is low, the session sends a fixed default byte on every beat and leaves the FIFO alone. If a bus error is reported while preload mode is on, a lockout flag is raised. While that flag is set, writes into the FIFO are accepted and thrown away. The flag is cleared by writing a one to it. An interrupt output reports the flag when its enable bit is set. With preload mode off, every read is served straight from the FIFO.

The FIFO write path and the serializer path are valid/ready streams. A FIFO write beat completes when `fw_valid` and `fw_ready` are both high. Back-pressure comes only from a full FIFO, and a locked block never back-pressures, because it drops the beat. A transmit beat completes when `tx_valid` and `tx_ready` are both high. While the serializer holds `tx_ready` low, the block keeps offering the same beat. Any FIFO pop happens only on a completed beat.

Top module: `i2c_tgt_preload_ctrl`

## Requirements
- R1: After reset, the preload enable, ready, interrupt enable and lockout state are all 0. No read session is open, so `tx_valid`, `stretch_o`, `fifo_rd_o` and `irq_o` are 0.
- R2: A cycle with `ctl_we` high loads the preload enable and the interrupt enable from `ctl_preload_i` and `ctl_irq_en_i`. The ready bit takes `ctl_ready_i` only when the written preload enable is 1; otherwise it becomes 0.
- R3: `err_i` sets the lockout flag on the next edge only while the current preload enable is 1. An error seen with preload off leaves the flag unchanged.
- R4: A cycle with `lock_we` high and `lock_wdata` 1 clears the lockout flag. With `lock_wdata` 0 the write has no effect. If a set and a clear land in the same cycle, the set wins.
- R5: While the lockout flag is 1, `fw_ready` is 1 and `fifo_wr_o` is 0, so the beat is dropped. While the flag is 0, `fw_ready` equals `!fifo_full_i`, `fifo_wr_o` equals `fw_valid & !fifo_full_i`, and `fifo_wdata_o` equals `fw_data`.
- R6: `irq_o` is 1 exactly when the lockout flag and the interrupt enable are both 1.
- R7: Suppose `rd_req_i` arrives with no session open while preload and ready are both 1. A FIFO-sourced session then opens on the next edge, and ready reads 0 from that edge on. This hardware clear wins over a firmware write in the same cycle.
- R8: Suppose `rd_req_i` arrives with no session open while preload is 1 and ready is 0. The session then offers `DEFAULT_BYTE` with `tx_valid` high on every cycle and never asserts `fifo_rd_o`.
- R9: Suppose `rd_req_i` arrives with no session open while preload is 0. The session then takes its data from the FIFO, and the ready bit is not changed by the read.
- R10: In a FIFO-sourced session, `tx_valid` equals `!fifo_empty_i` and `tx_data` equals `fifo_rdata_i`. `fifo_rd_o` is high on each completed beat. An empty FIFO gives `tx_valid` 0 and `stretch_o` 1.
- R11: `rd_done_i` closes an open session on the next edge. `rd_req_i` during an open session changes neither the session nor the ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_preload_i | input | 1 | Written preload enable |
| ctl_ready_i | input | 1 | Written ready bit |
| ctl_irq_en_i | input | 1 | Written lockout interrupt enable |
| lock_we | input | 1 | Lockout flag write strobe |
| lock_wdata | input | 1 | Lockout write value, 1 clears |
| preload_o | output | 1 | Current preload enable |
| ready_o | output | 1 | Current ready bit |
| lock_o | output | 1 | Current lockout flag |
| irq_o | output | 1 | Lockout interrupt |
| fw_valid | input | 1 | FIFO write beat valid |
| fw_data | input | DATA_W | FIFO write beat data |
| fw_ready | output | 1 | FIFO write beat accepted |
| fifo_full_i | input | 1 | External FIFO full |
| fifo_wr_o | output | 1 | Push strobe to external FIFO |
| fifo_wdata_o | output | DATA_W | Push data to external FIFO |
| fifo_empty_i | input | 1 | External FIFO empty |
| fifo_rdata_i | input | DATA_W | External FIFO head byte |
| fifo_rd_o | output | 1 | Pop strobe to external FIFO |
| rd_req_i | input | 1 | Bus engine: controller read started |
| rd_done_i | input | 1 | Bus engine: controller read finished |
| err_i | input | 1 | Bus engine: error seen |
| tx_valid | output | 1 | Byte offered to serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | DATA_W | Byte to serializer |
| stretch_o | output | 1 | Session open but no byte available |

## Verification
Assertions check on every cycle that a locked block never pushes into the FIFO and that an error under preload raises the flag. They also check that a zero written to the flag cannot clear it, that a consumed ready bit reads low one edge later, and that a default-byte session never pops the FIFO. Other behaviours depend on how events are ordered over a run, and only the bench scenarios can show them. These include a firmware write that collides with a hardware clear of ready, a set and a clear of the flag in the same cycle, and read requests that arrive inside an open session. The rest are sessions that open with preload off, stall on an empty FIFO, or are held up by serializer back-pressure.

// File: rtl/i2c_pl_pkg.sv
package i2c_pl_pkg;

  typedef enum logic {
    SRC_DEFAULT = 1'b0,
    SRC_FIFO    = 1'b1
  } tx_src_e;

  typedef struct packed {
    logic preload;
    logic ready;
    logic irq_en;
  } pl_ctl_t;

endpackage

// File: rtl/pl_ctrl_regs.sv
module pl_ctrl_regs
  import i2c_pl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ctl_we,
  input  pl_ctl_t ctl_wdata,
  input  logic    lock_we,
  input  logic    lock_wdata,
  input  logic    err_i,
  input  logic    consume_i,
  output logic    preload_o,
  output logic    ready_o,
  output logic    irq_en_o,
  output logic    lock_o,
  output logic    irq_o
);

  logic preload_q, ready_q, irq_en_q, lock_q;
  logic lock_set, lock_clr;

  assign lock_set = err_i & preload_q;
  assign lock_clr = lock_we & lock_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload_q <= 1'b0;
      ready_q   <= 1'b0;
      irq_en_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        preload_q <= ctl_wdata.preload;
        irq_en_q  <= ctl_wdata.irq_en;
        ready_q   <= ctl_wdata.preload & ctl_wdata.ready;
      end
      // hardware consumption overrides a firmware write in the same cycle
      if (consume_i) ready_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
    else if (lock_clr) lock_q <= 1'b0;
  end

  assign preload_o = preload_q;
  assign ready_o   = ready_q;
  assign irq_en_o  = irq_en_q;
  assign lock_o    = lock_q;
  assign irq_o     = lock_q & irq_en_q;

  AST_LOCK_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && preload_q) |=> lock_q); // R3
  AST_W0_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && lock_we && !lock_wdata) |=> lock_q); // R4
  AST_READY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |=> !ready_q); // R7

endmodule

// File: rtl/pl_wr_gate.sv
module pl_wr_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              fw_valid,
  input  logic [DATA_W-1:0] fw_data,
  output logic              fw_ready,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_wdata_o
);

  // a locked gate swallows beats instead of stalling the writer
  assign fw_ready     = lock_i | ~fifo_full_i;
  assign fifo_wr_o    = fw_valid & ~lock_i & ~fifo_full_i;
  assign fifo_wdata_o = fw_data;

  AST_NO_PUSH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |-> !fifo_wr_o); // R5
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full_i |-> !fifo_wr_o); // R5

endmodule

// File: rtl/pl_tx_session.sv
module pl_tx_session
  import i2c_pl_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter logic [DATA_W-1:0] DEFAULT_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic              rd_done_i,
  input  logic              preload_i,
  input  logic              ready_i,
  output logic              consume_o,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic              fifo_rd_o,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              stretch_o
);

  logic    active_q;
  tx_src_e src_q;
  logic    start;

  assign start     = rd_req_i & ~active_q;
  assign consume_o = start & preload_i & ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      src_q    <= SRC_DEFAULT;
    end else if (start) begin
      active_q <= 1'b1;
      src_q    <= (!preload_i || ready_i) ? SRC_FIFO : SRC_DEFAULT;
    end else if (active_q && rd_done_i) begin
      active_q <= 1'b0;
    end
  end

  always_comb begin
    tx_valid  = 1'b0;
    tx_data   = DEFAULT_BYTE;
    fifo_rd_o = 1'b0;
    if (active_q) begin
      if (src_q == SRC_FIFO) begin
        tx_valid  = ~fifo_empty_i;
        tx_data   = fifo_rdata_i;
        fifo_rd_o = ~fifo_empty_i & tx_ready;
      end else begin
        tx_valid  = 1'b1;
      end
    end
  end

  assign stretch_o = active_q & ~tx_valid;

  AST_DEFAULT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && src_q == SRC_DEFAULT) |-> !fifo_rd_o); // R8
  AST_POP_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> (tx_valid && tx_ready)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!tx_valid && !stretch_o)); // R11

endmodule

// File: rtl/i2c_tgt_preload_ctrl.sv
module i2c_tgt_preload_ctrl
  import i2c_pl_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter logic [DATA_W-1:0] DEFAULT_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_preload_i,
  input  logic              ctl_ready_i,
  input  logic              ctl_irq_en_i,
  input  logic              lock_we,
  input  logic              lock_wdata,
  output logic              preload_o,
  output logic              ready_o,
  output logic              lock_o,
  output logic              irq_o,
  input  logic              fw_valid,
  input  logic [DATA_W-1:0] fw_data,
  output logic              fw_ready,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic              fifo_rd_o,
  input  logic              rd_req_i,
  input  logic              rd_done_i,
  input  logic              err_i,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              stretch_o
);

  pl_ctl_t ctl_w;
  logic    consume, irq_en, lock;

  assign ctl_w.preload = ctl_preload_i;
  assign ctl_w.ready   = ctl_ready_i;
  assign ctl_w.irq_en  = ctl_irq_en_i;
  assign lock_o        = lock;

  pl_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_w),
    .lock_we    (lock_we),
    .lock_wdata (lock_wdata),
    .err_i      (err_i),
    .consume_i  (consume),
    .preload_o  (preload_o),
    .ready_o    (ready_o),
    .irq_en_o   (irq_en),
    .lock_o     (lock),
    .irq_o      (irq_o)
  );

  pl_wr_gate #(.DATA_W(DATA_W)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_i       (lock),
    .fw_valid     (fw_valid),
    .fw_data      (fw_data),
    .fw_ready     (fw_ready),
    .fifo_full_i  (fifo_full_i),
    .fifo_wr_o    (fifo_wr_o),
    .fifo_wdata_o (fifo_wdata_o)
  );

  pl_tx_session #(.DATA_W(DATA_W), .DEFAULT_BYTE(DEFAULT_BYTE)) u_sess (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_i     (rd_req_i),
    .rd_done_i    (rd_done_i),
    .preload_i    (preload_o),
    .ready_i      (ready_o),
    .consume_o    (consume),
    .fifo_empty_i (fifo_empty_i),
    .fifo_rdata_i (fifo_rdata_i),
    .fifo_rd_o    (fifo_rd_o),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .stretch_o    (stretch_o)
  );

  AST_IRQ_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (lock_o && irq_en)); // R6
  AST_READY_NEEDS_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_we) && !$past(ctl_preload_i)) |-> !ready_o); // R2

endmodule

// File: tb/i2c_tgt_preload_ctrl_tb_top.sv
module i2c_tgt_preload_ctrl_tb_top;
  localparam int DW = 8;
  localparam logic [DW-1:0] DEF = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ctl_we = 0, ctl_pre = 0, ctl_rdy = 0, ctl_ien = 0, lock_we = 0, lock_wd = 0;
  logic fw_valid = 0, fifo_full = 0, fifo_empty = 1, rd_req = 0, rd_done = 0, err = 0, tx_ready = 0;
  logic [DW-1:0] fw_data = 0, fifo_rdata = 0;
  logic preload_o, ready_o, lock_o, irq_o, fw_ready, fifo_wr, fifo_rd, tx_valid, stretch;
  logic [DW-1:0] fifo_wdata, tx_data;

  i2c_tgt_preload_ctrl #(.DATA_W(DW), .DEFAULT_BYTE(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_preload_i(ctl_pre),
    .ctl_ready_i(ctl_rdy), .ctl_irq_en_i(ctl_ien), .lock_we(lock_we), .lock_wdata(lock_wd),
    .preload_o(preload_o), .ready_o(ready_o), .lock_o(lock_o), .irq_o(irq_o),
    .fw_valid(fw_valid), .fw_data(fw_data), .fw_ready(fw_ready), .fifo_full_i(fifo_full),
    .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata), .fifo_empty_i(fifo_empty),
    .fifo_rdata_i(fifo_rdata), .fifo_rd_o(fifo_rd), .rd_req_i(rd_req), .rd_done_i(rd_done),
    .err_i(err), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .stretch_o(stretch)
  );

  int n_chk = 0, n_fail = 0;
  logic m_pre = 0, m_rdy = 0, m_lock = 0, m_ien = 0, m_act = 0, m_src = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_txv();
    return m_act && (m_src ? !fifo_empty : 1'b1);
  endfunction
  function automatic logic [DW-1:0] exp_txd();
    return (m_act && m_src) ? fifo_rdata : DEF;
  endfunction

  // inputs already applied; check outputs, then advance one edge and the model
  task automatic tick();
    logic n_rdy, n_lock;
    #1;
    chk("R2 preload", preload_o, m_pre);
    chk("R7 ready", ready_o, m_rdy);
    chk("R3 lock", lock_o, m_lock);
    chk("R6 irq", irq_o, m_lock & m_ien);
    chk("R5 fw_ready", fw_ready, m_lock | !fifo_full);
    chk("R5 fifo_wr", fifo_wr, fw_valid & !m_lock & !fifo_full);
    if (fifo_wr) chk("R5 wdata", fifo_wdata, fw_data);
    chk("R10 tx_valid", tx_valid, exp_txv());
    if (tx_valid) chk("R8 tx_data", tx_data, exp_txd());
    chk("R10 fifo_rd", fifo_rd, m_act & m_src & !fifo_empty & tx_ready);
    chk("R10 stretch", stretch, m_act & !exp_txv());
    @(posedge clk);
    n_rdy = m_rdy;
    if (ctl_we) n_rdy = ctl_pre & ctl_rdy;
    if (rd_req && !m_act && m_pre && m_rdy) n_rdy = 0;
    n_lock = (err && m_pre) ? 1'b1 : ((lock_we && lock_wd) ? 1'b0 : m_lock);
    if (!m_act && rd_req) begin
      m_act = 1; m_src = !m_pre || m_rdy;
    end else if (m_act && rd_done) m_act = 0;
    if (ctl_we) begin m_pre = ctl_pre; m_ien = ctl_ien; end
    m_rdy = n_rdy; m_lock = n_lock;
    @(negedge clk);
  endtask

  task automatic idle();
    ctl_we = 0; lock_we = 0; lock_wd = 0; fw_valid = 0; rd_req = 0; rd_done = 0; err = 0;
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 preload", preload_o, 0); chk("R1 ready", ready_o, 0);
    chk("R1 lock", lock_o, 0); chk("R1 irq", irq_o, 0);
    chk("R1 tx_valid", tx_valid, 0); chk("R1 stretch", stretch, 0);
    // R2: ready refused when preload written 0
    ctl_we = 1; ctl_pre = 0; ctl_rdy = 1; ctl_ien = 1; tick(); idle();
    chk("R2 ready refused", ready_o, 0);
    // R3: error with preload off ignored
    err = 1; tick(); idle(); chk("R3 err ignored", lock_o, 0);
    // enable preload, ready=1, then error raises lock
    ctl_we = 1; ctl_pre = 1; ctl_rdy = 1; tick(); idle();
    err = 1; tick(); idle(); chk("R3 lock set", lock_o, 1); chk("R6 irq", irq_o, 1);
    // R5: locked write is dropped
    fw_valid = 1; fw_data = 8'h5A; fifo_full = 1; tick(); idle(); fifo_full = 0;
    // R4: write 0 no effect, set+clear -> set
    lock_we = 1; lock_wd = 0; tick(); idle(); chk("R4 w0", lock_o, 1);
    lock_we = 1; lock_wd = 1; err = 1; tick(); idle(); chk("R4 set wins", lock_o, 1);
    lock_we = 1; lock_wd = 1; tick(); idle(); chk("R4 cleared", lock_o, 0);
    // R7: read consumes ready; firmware ready write same cycle loses
    fifo_empty = 0; fifo_rdata = 8'h3C; tx_ready = 1;
    rd_req = 1; ctl_we = 1; ctl_pre = 1; ctl_rdy = 1; tick(); idle();
    chk("R7 ready cleared", ready_o, 0);
    rd_req = 1; tick(); idle();          // R11: request inside session ignored
    fifo_empty = 1; tick();              // R10: empty -> stretch
    rd_done = 1; tick(); idle();
    chk("R11 closed", tx_valid, 0);
    // R8: read with ready 0 sends default
    fifo_empty = 0; rd_req = 1; tick(); idle(); tick(); rd_done = 1; tick(); idle();
    // R9: preload off, ready untouched
    ctl_we = 1; ctl_pre = 0; tick(); idle(); rd_req = 1; tick(); idle(); tick();
    rd_done = 1; tick(); idle();
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      ctl_we = ($urandom % 10) == 0; ctl_pre = ($urandom % 4) != 0;
      ctl_rdy = $urandom; ctl_ien = $urandom;
      lock_we = ($urandom % 6) == 0; lock_wd = $urandom;
      err = ($urandom % 15) == 0;
      fw_valid = $urandom; fw_data = $urandom; fifo_full = ($urandom % 4) == 0;
      fifo_empty = ($urandom % 4) == 0; fifo_rdata = $urandom;
      rd_req = ($urandom % 6) == 0; rd_done = ($urandom % 8) == 0; tx_ready = $urandom;
      tick();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule